// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. A transmitter turns a byte into a serial frame on `txd`. A receiver rebuilds characters from `rxd`. Both run from one oversampling tick, `tick16`, which comes from a baud generator outside the block and pulses once per sixteenth of a bit time. Software reaches the block through a small register port with four addresses: transmit buffer, receive buffer, control, and a write-only command register.

The control register selects one of three frame formats, the number of stop bits, odd or even parity, and whether parity, framing and overrun errors are detected. The three formats are eight data bits with no parity, eight data bits with parity, and seven data bits with parity. The receiver enable and the three sticky error flags sit outside the control register. They change only when the command register is written, so a control write can never switch on the receiver or clear an error that software has not yet seen. The line idles high. Each frame starts with one low start bit, and data bits go out least significant bit first.

Top module: `serial_port_core`

## Requirements
- R1: After reset `txd` is high and address 2 reads as zero. Address 2 reads the control value in bits [6:0], receiver enable in [7], framing error in [8], parity error in [9], overrun in [10], transmitter busy in [11] and receive-buffer-full in [12].
- R2: A write to address 0 while the transmitter is idle starts a frame on the next tick. The frame is one low start bit followed by the data bits, least significant bit first, and every bit lasts 16 ticks. A write to address 0 while a frame is pending or in progress is ignored. The line stays high when no frame is being sent.
- R3: Control bits [1:0] select the format: 0 is 8 data bits with no parity, 1 is 8 data bits plus a parity bit, 2 is 7 data bits plus a parity bit, and 3 behaves as 0. The parity bit follows the last data bit.
- R4: With control bit [4] set, the data bits plus the parity bit carry an odd number of ones. With it clear, they carry an even number.
- R5: Control bit [2] set gives two stop bits, and clear gives one. The transmitter stays busy until the last stop bit has ended.
- R6: Writing command bit [0] to address 3 enables the receiver, and command bit [1] disables it. While the receiver is disabled, frames on `rxd` are ignored and the buffer-full flag stays clear.
- R7: The receiver samples each bit near the middle of its 16 ticks. It stores the character in the receive buffer (address 1) and sets buffer-full. Reading address 1 clears buffer-full. In format 2 the character sits in bits [6:0] and bit [7] reads 0.
- R8: When the first stop bit is sampled low and control bit [5] is set, the framing error flag is set. With bit [5] clear, a bad stop bit sets no flag.
- R9: When parity checking (control bit [3]) is on and the received parity bit does not match the selected sense, the parity error flag is set.
- R10: When a character completes while buffer-full is still set and control bit [6] is set, the overrun flag is set, and the new character replaces the old one in the buffer.
- R11: The error flags are sticky. Framing, parity and overrun are cleared only by writing command bits [2], [3] and [4] to address 3. Control writes leave them unchanged.
- R12: Control writes never change the receiver enable, even when bit [7] of the written value is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears buffer-full on address 1) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, combinational from the address |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line, asynchronous |

## Verification
The assertions check several rules on every cycle. The transmit line stays high whenever the transmitter is idle, and a frame only starts on a tick. An error flag never falls without its clear command in the previous cycle. The receiver enable never moves except after a command write, and an overrun only rises when the buffer was already full. Other behaviours can only be shown by the bench's scenarios: the exact bit sequence of each format and parity sense, the difference between one and two stop bits, the masking of seven-bit characters, and the flags raised by corrupted frames. The bench covers these with a full byte sweep looped back from `txd` to `rxd`, and with frames it drives by hand.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [1:0] {
        FMT_8N  = 2'd0,
        FMT_8P  = 2'd1,
        FMT_7P  = 2'd2,
        FMT_RSV = 2'd3
    } fmt_e;

    // control register layout, LSB last
    typedef struct packed {
        logic ovr_en;
        logic frm_en;
        logic odd;
        logic par_en;
        logic two_stop;
        fmt_e fmt;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int CHAR_W = 8;

    // command register bit positions
    localparam int CMD_SET_RX = 0;
    localparam int CMD_CLR_RX = 1;
    localparam int CMD_CLR_FE = 2;
    localparam int CMD_CLR_PE = 3;
    localparam int CMD_CLR_OE = 4;

    typedef struct packed {
        ctrl_t             ctrl;
        logic              rx_en;
        logic              fe;
        logic              pe;
        logic              oe;
        logic              full;
        logic [CHAR_W-1:0] rbuf;
    } regs_t;

    function automatic logic [3:0] data_bits(input fmt_e f);
        return (f == FMT_7P) ? 4'd7 : 4'd8;
    endfunction

    function automatic logic has_parity(input fmt_e f);
        return (f == FMT_8P) || (f == FMT_7P);
    endfunction

endpackage

// File: rtl/sp_tx.sv
module sp_tx
    import sp_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [CHAR_W-1:0] din,
    input  fmt_e              fmt,
    input  logic              odd,
    input  logic              two_stop,
    output logic              txd,
    output logic              busy,
    output logic              active
);
    localparam int CNT_W   = $clog2(TICKS_PER_BIT);
    localparam int FRAME_W = CHAR_W + 4;
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(TICKS_PER_BIT - 1);

    typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_SHIFT} tx_phase_e;

    typedef struct packed {
        tx_phase_e          phase;
        logic [FRAME_W-1:0] frame;
        logic [3:0]         left;
        logic [CNT_W-1:0]   tcnt;
    } tx_st_t;

    tx_st_t s_d, s_q;
    logic [FRAME_W-1:0] built;
    logic [3:0]         nd;
    logic               np;
    logic               par;

    // assemble start, data, parity and stop bits; unset positions idle high
    always_comb begin
        nd    = data_bits(fmt);
        np    = has_parity(fmt);
        par   = odd;
        built = '1;
        built[0] = 1'b0;
        for (int i = 0; i < CHAR_W; i++) begin
            if (4'(i) < nd) begin
                built[1 + i] = din[i];
                par          = par ^ din[i];
            end
        end
        if (np) built[1 + nd] = par;
    end

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            TX_IDLE: begin
                if (load) begin
                    s_d.frame = built;
                    s_d.left  = 4'd2 + nd + {3'b0, np} + {3'b0, two_stop};
                    s_d.phase = TX_WAIT;
                end
            end
            TX_WAIT: begin
                if (tick) begin
                    s_d.phase = TX_SHIFT;
                    s_d.tcnt  = '0;
                end
            end
            TX_SHIFT: begin
                if (tick) begin
                    if (s_q.tcnt == LAST_TICK) begin
                        s_d.tcnt  = '0;
                        s_d.frame = {1'b1, s_q.frame[FRAME_W-1:1]};
                        s_d.left  = s_q.left - 4'd1;
                        if (s_q.left == 4'd1) s_d.phase = TX_IDLE;
                    end else begin
                        s_d.tcnt = s_q.tcnt + 1'b1;
                    end
                end
            end
            default: s_d.phase = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: TX_IDLE, frame: '1, left: '0, tcnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign txd    = (s_q.phase == TX_SHIFT) ? s_q.frame[0] : 1'b1;
    assign busy   = (s_q.phase != TX_IDLE);
    assign active = (s_q.phase == TX_SHIFT);

endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import sp_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              enable,
    input  fmt_e              fmt,
    input  logic              odd,
    output logic              done,
    output logic [CHAR_W-1:0] data,
    output logic              stop_ok,
    output logic              par_bad
);
    localparam int CNT_W = $clog2(TICKS_PER_BIT);
    localparam logic [CNT_W-1:0] MID       = CNT_W'(TICKS_PER_BIT / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(TICKS_PER_BIT - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   run;
        logic [CNT_W-1:0]       tcnt;
        logic [3:0]             idx;
        logic [CHAR_W-1:0]      sh;
        logic                   pbit;
        logic                   done;
        logic [CHAR_W-1:0]      data;
        logic                   stop_ok;
        logic                   par_bad;
    } rx_st_t;

    rx_st_t s_d, s_q;
    logic              line;
    logic [3:0]        nd;
    logic              np;
    logic [3:0]        last;
    logic [CHAR_W-1:0] word;

    assign line = s_q.sync[SYNC_STAGES-1];
    assign nd   = data_bits(fmt);
    assign np   = has_parity(fmt);
    assign last = 4'd1 + nd + {3'b0, np};
    assign word = (nd == 4'd7) ? {1'b0, s_q.sh[CHAR_W-1:1]} : s_q.sh;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], rxd};
        if (!enable) begin
            s_d.run = 1'b0;
        end else if (!s_q.run) begin
            if (tick && !line) begin
                s_d.run  = 1'b1;
                s_d.tcnt = '0;
                s_d.idx  = '0;
            end
        end else if (tick) begin
            s_d.tcnt = (s_q.tcnt == LAST_TICK) ? '0 : s_q.tcnt + 1'b1;
            if (s_q.tcnt == MID) begin
                if (s_q.idx == 4'd0) begin
                    // a start bit that is high again at its middle was a glitch
                    if (line) s_d.run = 1'b0;
                    else      s_d.idx = 4'd1;
                end else if (s_q.idx <= nd) begin
                    s_d.sh  = {line, s_q.sh[CHAR_W-1:1]};
                    s_d.idx = s_q.idx + 4'd1;
                end else if (s_q.idx < last) begin
                    s_d.pbit = line;
                    s_d.idx  = s_q.idx + 4'd1;
                end else begin
                    s_d.run     = 1'b0;
                    s_d.done    = 1'b1;
                    s_d.data    = word;
                    s_d.stop_ok = line;
                    s_d.par_bad = np && ((^word ^ s_q.pbit) != odd);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{sync: '1, run: 1'b0, tcnt: '0, idx: '0, sh: '0, pbit: 1'b0,
                     done: 1'b0, data: '0, stop_ok: 1'b1, par_bad: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done    = s_q.done;
    assign data    = s_q.data;
    assign stop_ok = s_q.stop_ok;
    assign par_bad = s_q.par_bad;

endmodule

// File: rtl/serial_port_core.sv
module serial_port_core
    import sp_pkg::*;
#(
    parameter int BUS_W         = 16,
    parameter int TICKS_PER_BIT = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             txd,
    input  logic             rxd
);
    localparam logic [1:0] ADDR_TX   = 2'd0;
    localparam logic [1:0] ADDR_RX   = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] ADDR_CMD  = 2'd3;

    regs_t r_d, r_q;

    logic              wr_tx, wr_ctrl, wr_cmd, rd_rx;
    logic              tx_busy, tx_active;
    logic              rx_done, rx_stop_ok, rx_par_bad;
    logic [CHAR_W-1:0] rx_data;
    logic              unused_bits;

    assign wr_tx       = bus_wr && (bus_addr == ADDR_TX);
    assign wr_ctrl     = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_cmd      = bus_wr && (bus_addr == ADDR_CMD);
    assign rd_rx       = bus_rd && (bus_addr == ADDR_RX);
    assign unused_bits = ^bus_wdata[BUS_W-1:CHAR_W];

    sp_tx #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .load     (wr_tx),
        .din      (bus_wdata[CHAR_W-1:0]),
        .fmt      (r_q.ctrl.fmt),
        .odd      (r_q.ctrl.odd),
        .two_stop (r_q.ctrl.two_stop),
        .txd      (txd),
        .busy     (tx_busy),
        .active   (tx_active)
    );

    sp_rx #(.TICKS_PER_BIT(TICKS_PER_BIT), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .rxd     (rxd),
        .enable  (r_q.rx_en),
        .fmt     (r_q.ctrl.fmt),
        .odd     (r_q.ctrl.odd),
        .done    (rx_done),
        .data    (rx_data),
        .stop_ok (rx_stop_ok),
        .par_bad (rx_par_bad)
    );

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) r_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        if (wr_cmd) begin
            if (bus_wdata[CMD_SET_RX]) r_d.rx_en = 1'b1;
            if (bus_wdata[CMD_CLR_RX]) r_d.rx_en = 1'b0;
            if (bus_wdata[CMD_CLR_FE]) r_d.fe    = 1'b0;
            if (bus_wdata[CMD_CLR_PE]) r_d.pe    = 1'b0;
            if (bus_wdata[CMD_CLR_OE]) r_d.oe    = 1'b0;
        end
        if (rd_rx) r_d.full = 1'b0;
        // a completing character wins over a clear in the same cycle
        if (rx_done) begin
            r_d.rbuf = rx_data;
            r_d.full = 1'b1;
            if (r_q.full && !rd_rx && r_q.ctrl.ovr_en) r_d.oe = 1'b1;
            if (!rx_stop_ok && r_q.ctrl.frm_en)         r_d.fe = 1'b1;
            if (rx_par_bad && r_q.ctrl.par_en)          r_d.pe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ctrl: ctrl_t'('0), rx_en: 1'b0, fe: 1'b0, pe: 1'b0,
                     oe: 1'b0, full: 1'b0, rbuf: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_RX:   bus_rdata = BUS_W'(r_q.rbuf);
            ADDR_CTRL: bus_rdata = BUS_W'({r_q.full, tx_busy, r_q.oe, r_q.pe,
                                           r_q.fe, r_q.rx_en, r_q.ctrl});
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sp_checker.sv
module sp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick16,
    input logic       txd,
    input logic       tx_busy,
    input logic       tx_active,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [4:0] cmd_bits,
    input logic       fe,
    input logic       pe,
    input logic       oe,
    input logic       rx_en,
    input logic       rx_full
);
    logic cmd_wr;
    assign cmd_wr = bus_wr && (bus_addr == 2'd3);

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    assert_start_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> $past(tick16));

    assert_fe_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fe) |-> $past(cmd_wr && cmd_bits[2]));

    assert_pe_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pe) |-> $past(cmd_wr && cmd_bits[3]));

    assert_oe_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe) |-> $past(cmd_wr && cmd_bits[4]));

    assert_oe_needs_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(rx_full));

    assert_rxen_by_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_en) |-> $past(cmd_wr));

endmodule

bind serial_port_core sp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick16    (tick16),
    .txd       (txd),
    .tx_busy   (tx_busy),
    .tx_active (tx_active),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .cmd_bits  (bus_wdata[4:0]),
    .fe        (r_q.fe),
    .pe        (r_q.pe),
    .oe        (r_q.oe),
    .rx_en     (r_q.rx_en),
    .rx_full   (r_q.full)
);

// File: tb/tb_serial_port_core.sv
module tb_serial_port_core;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLK    = 32;   // 16 ticks, one tick every 2 clocks
    localparam int HALF_BIT   = 16;
    localparam int WDOG       = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick16 = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        txd, rxd;
    logic        loop_sel = 1'b1;
    logic        rxd_drv = 1'b1;
    int          n_chk = 0, n_fail = 0;

    assign rxd = loop_sel ? txd : rxd_drv;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) tick16 <= ~tick16;

    serial_port_core dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .txd(txd), .rxd(rxd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic capture(input int n, output logic [11:0] bits, output int wait_cyc);
        bits = '1;
        wait_cyc = 0;
        while (txd !== 1'b0 && wait_cyc < 400) begin
            @(negedge clk);
            wait_cyc++;
        end
        repeat (HALF_BIT) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            bits[i] = txd;
            if (i < n - 1) repeat (BIT_CLK) @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        logic [15:0] st;
        int g = 0;
        rd(2'd2, st);
        while (st[11] && g < 2000) begin
            rd(2'd2, st);
            g++;
        end
    endtask

    // loopback: transmit one character, decode txd, then read it back
    task automatic char_test(input logic [6:0] c, input logic [7:0] ch, input string tag);
        int nd, p, len, wc;
        logic par;
        logic [11:0] exp_f, got;
        logic [7:0] mask;
        logic [15:0] st, rv;
        nd   = (c[1:0] == 2'd2) ? 7 : 8;
        p    = (c[1:0] == 2'd1 || c[1:0] == 2'd2) ? 1 : 0;
        mask = (nd == 7) ? 8'h7F : 8'hFF;
        par  = (^(ch & mask)) ^ c[4];
        exp_f = '1;
        exp_f[0] = 1'b0;
        for (int i = 0; i < nd; i++) exp_f[1 + i] = ch[i];
        if (p == 1) exp_f[1 + nd] = par;
        len = 2 + nd + p;
        wr(2'd2, {9'd0, c});
        wr(2'd0, {8'd0, ch});
        capture(len, got, wc);
        check(wc <= 2, {tag, " R2 start on next tick"}, wc, 2);
        check((got & ((12'd1 << len) - 1)) == (exp_f & ((12'd1 << len) - 1)),
              {tag, " R3 R4 frame bits"}, got, exp_f);
        repeat (BIT_CLK) @(negedge clk);
        rd(2'd2, st);
        check(st[11] == c[2], {tag, " R5 stop count"}, st[11], c[2]);
        check(st[12] == 1'b1 && st[9:8] == 2'b00, {tag, " R7 received clean"}, st[12:8], 5'h10);
        rd(2'd1, rv);
        check(rv[7:0] == (ch & mask), {tag, " R7 rx data"}, rv, ch & mask);
        wait_idle();
    endtask

    task automatic rx_send(input logic [11:0] f, input int n);
        for (int i = 0; i < n; i++) begin
            rxd_drv = f[i];
            repeat (BIT_CLK) @(negedge clk);
        end
        rxd_drv = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    function automatic logic [11:0] frame8p(input logic [7:0] d, input logic par, input logic stp);
        return {1'b1, stp, par, d, 1'b0};
    endfunction

    initial begin : watchdog
        repeat (WDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", WDOG);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [15:0] st, rv;
        logic [11:0] got;
        int wc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd2, st);
        check(st == 16'h0 && txd == 1'b1, "R1 reset state", st, 0);

        // R12 control write with bit 7 set leaves receiver off
        wr(2'd2, 16'h00FF);
        rd(2'd2, st);
        check(st[7] == 1'b0 && st[6:0] == 7'h7F, "R12 ctrl cannot enable rx", st, 16'h7F);

        // R6 enable receiver through the command register
        wr(2'd3, 16'h0001);
        rd(2'd2, st);
        check(st[7] == 1'b1, "R6 rx enable by command", st[7], 1);

        // full byte sweep, 8 data bits, no parity, one stop
        for (int ch = 0; ch < 256; ch++) char_test(7'h60, 8'(ch), "8N");
        // 7 data bits plus odd parity, two stops
        for (int ch = 3; ch < 256; ch += 17) char_test(7'h7E, 8'(ch), "7P-odd-2stop");
        // 8 data bits, even parity, one stop
        for (int ch = 0; ch < 256; ch += 19) char_test(7'h69, 8'(ch), "8P-even");
        // 8 data bits, odd parity, two stops
        for (int ch = 5; ch < 256; ch += 23) char_test(7'h7D, 8'(ch), "8P-odd-2stop");
        // code 3 behaves as 8 data bits without parity
        for (int ch = 1; ch < 256; ch += 51) char_test(7'h63, 8'(ch), "fmt3 R3");

        // R2 write while busy is ignored
        wr(2'd2, 16'h0060);
        wr(2'd0, 16'h00A5);
        wr(2'd0, 16'h003C);
        capture(10, got, wc);
        check(got[9:0] == {1'b1, 8'hA5, 1'b0}, "R2 second write ignored", got[9:0], {1'b1, 8'hA5, 1'b0});
        repeat (3 * BIT_CLK) @(negedge clk);
        rd(2'd2, st);
        check(st[11] == 1'b0 && txd == 1'b1, "R2 no second frame", st[11], 0);
        rd(2'd1, rv);
        check(rv[7:0] == 8'hA5, "R2 R7 looped byte", rv, 8'hA5);

        // hand-driven frames: 8 bits even parity, all checks on
        loop_sel = 1'b0;
        wr(2'd2, 16'h0069);

        rx_send(frame8p(8'h55, 1'b1, 1'b1), 11);   // wrong parity (0x55 has even ones)
        rd(2'd2, st);
        check(st[9] == 1'b1 && st[8] == 1'b0, "R9 parity error", st[10:8], 3'b010);
        rd(2'd1, rv);
        check(rv[7:0] == 8'h55, "R9 data kept", rv, 8'h55);
        wr(2'd2, 16'h0069);
        rd(2'd2, st);
        check(st[9] == 1'b1, "R11 ctrl write keeps PE", st[9], 1);
        wr(2'd3, 16'h0008);
        rd(2'd2, st);
        check(st[9] == 1'b0 && st[7] == 1'b1, "R11 PE cleared by command", st[9:7], 3'b001);

        rx_send(frame8p(8'h81, 1'b0, 1'b0), 11);   // low stop bit
        rd(2'd2, st);
        check(st[8] == 1'b1 && st[9] == 1'b0, "R8 framing error", st[10:8], 3'b001);
        rd(2'd1, rv);
        wr(2'd3, 16'h0004);
        rd(2'd2, st);
        check(st[8] == 1'b0, "R11 FE cleared by command", st[8], 0);

        wr(2'd2, 16'h0049);                       // framing detection off
        rx_send(frame8p(8'h81, 1'b0, 1'b0), 11);
        rd(2'd2, st);
        check(st[8] == 1'b0 && st[12] == 1'b1, "R8 framing detection disabled", st[12:8], 5'h10);
        rd(2'd1, rv);

        wr(2'd2, 16'h0069);
        rx_send(frame8p(8'h11, 1'b0, 1'b1), 11);
        rx_send(frame8p(8'h22, 1'b0, 1'b1), 11);
        rd(2'd2, st);
        check(st[10] == 1'b1 && st[9:8] == 2'b00, "R10 overrun flagged", st[10:8], 3'b100);
        rd(2'd1, rv);
        check(rv[7:0] == 8'h22, "R10 newest char kept", rv, 8'h22);
        wr(2'd3, 16'h0010);
        rd(2'd2, st);
        check(st[10] == 1'b0, "R11 OE cleared by command", st[10], 0);

        // R6 disabled receiver ignores traffic
        wr(2'd3, 16'h0002);
        rx_send(frame8p(8'h33, 1'b0, 1'b1), 11);
        rd(2'd2, st);
        check(st[7] == 1'b0 && st[12] == 1'b0, "R6 disabled rx ignores frame", st[12:7], 0);
        wr(2'd3, 16'h0001);
        rx_send(frame8p(8'h44, 1'b0, 1'b1), 11);
        rd(2'd1, rv);
        check(rv[7:0] == 8'h44, "R6 R7 re-enabled rx", rv, 8'h44);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule